// File: doc/BRIEF.md
# Spaced-one-hot escape transmitter

This block is the transmit half of the low-power escape signalling on one data lane. It owns the two single-ended line bits, written here as LP-PN with `lp_p` first and `lp_n` second, so LP-10 means `lp_p`=1 and `lp_n`=0. At rest it holds the Stop state (LP-11). On a request it drives the escape entry pattern. It then sends an 8-bit entry command and, for the low-power data command, a stream of payload bytes. Each bit goes out as a mark followed by a space, least significant bit first. The block finishes by driving the exit pattern that returns the lane to Stop.

Every line state lasts `period` clock cycles, a programmable count. The exception is the wake-up mark after the ultra-low-power state, which lasts `wake_len` cycles. The payload arrives over a valid/ready byte port, and the last byte is flagged. After the ultra-low-power command the block parks the lane in LP-00 until a wake request arrives. Any other command value is sent and followed at once by the exit pattern.

Top module: `esc_lane_tx`

## Requirements
- R1: After reset, and whenever idle, the lines are LP-11, `busy` is 0 and `data_ready` is 0. `busy` is 1 in every cycle the block is not idle.
- R2: When `esc_req` is sampled high at a clock edge while idle, the lines carry LP-10, LP-00, LP-01, LP-00 starting in the next cycle. Each state lasts `period` cycles.
- R3: The command follows the entry pattern with bit 0 first. Each bit is a mark for `period` cycles (LP-10 for a 1, LP-01 for a 0) and then LP-00 for `period` cycles.
- R4: A `period` of 0 behaves as 1, and a `wake_len` of 0 behaves as 1.
- R5: When the command equals `LPDT_CMD` (default 8'h87), the block holds LP-00 after the command with `data_ready` high. A byte is taken at an edge where `data_valid` and `data_ready` are both high. It is sent in the R3 form starting in the next cycle, and `data_ready` is low while it is sent.
- R6: While the block waits for a byte and `data_valid` stays low, the lines stay LP-00 for as long as the wait lasts.
- R7: After a byte taken with `data_last` high, the lines carry LP-10 for `period` cycles, then LP-11 for `period` cycles, and then the block is idle. After any other byte the block returns to the R5 wait.
- R8: When the command equals `ULPS_CMD` (default 8'h78), LP-00 is held after the command until `wake_req` is sampled high. The lines then carry LP-10 for `wake_len` cycles, then LP-11 for `period` cycles, and then the block is idle. `wake_req` has no effect at any other time.
- R9: Any other command value is followed directly by the R7 exit pattern.
- R10: `esc_req` sampled while `busy` is high has no effect.
- R11: The lines never step straight between LP-01 and LP-10. From LP-11 they move only to LP-10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | PER_W | Cycles per line state (0 acts as 1) |
| wake_len | input | WAKE_W | Cycles of the wake-up mark (0 acts as 1) |
| esc_req | input | 1 | Start an escape sequence (taken only when idle) |
| esc_cmd | input | 8 | Entry command, sampled with `esc_req` |
| wake_req | input | 1 | Leave the ultra-low-power hold |
| data_valid | input | 1 | Payload byte available |
| data_byte | input | 8 | Payload byte |
| data_last | input | 1 | Marks the final payload byte |
| data_ready | output | 1 | Block takes a byte this cycle when valid |
| busy | output | 1 | Sequence in progress |
| lp_p | output | 1 | First line bit |
| lp_n | output | 1 | Second line bit |

## Verification
The bench compares the line pair, `data_ready` and `busy` against a queue of expected line states in every cycle. This catches a wrong bit order or a mark polarity swapped between LP-10 and LP-01, either of which would corrupt the command and the payload bytes. Payload bytes come back to back, after a long stall, and with the last-byte flag. A design that dropped the space after a mark, ended the stream early, or failed to hold LP-00 while starved would drift against the expected queue. The ultra-low-power path is run with a normal and a zero wake length, and `period` is set to 0 and 1. A wake pulse that arrives outside the hold and an `esc_req` issued mid-sequence must both leave the line waveform unchanged.

// File: rtl/esc_tx_pkg.sv
// Shared types for the escape transmitter: the sequencer phases and
// the line state codes written {lp_p, lp_n}.
package esc_tx_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_ENT_10, S_ENT_00A, S_ENT_01, S_ENT_00B,
        S_CMD, S_DWAIT, S_DATA, S_ULPS, S_WAKE, S_EXIT_10, S_EXIT_11
    } esc_state_t;

    localparam logic [1:0] LINE_STOP  = 2'b11;
    localparam logic [1:0] LINE_MARK1 = 2'b10;
    localparam logic [1:0] LINE_MARK0 = 2'b01;
    localparam logic [1:0] LINE_SPACE = 2'b00;

endpackage

// File: rtl/esc_phase_timer.sv
// Down-counter that times one line-state period.
// Assumes: load is raised in the cycle before a new phase starts; a
// length of 0 is treated as 1. done is high in the last cycle of a phase.
module esc_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    // Reload on a phase start, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);

    // R4: a reload never leaves a count above the requested length minus one
    a_r4_reload_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt < (($past(len) == '0) ? W'(1) : $past(len))));
endmodule

// File: rtl/esc_bit_serializer.sv
// Shifts one byte out as mark/space halves, bit 0 first.
// Assumes: load and adv are never raised together; adv is raised once
// per finished half. at_end is high during the space of the last bit.
module esc_bit_serializer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              adv,
    output logic              bit_now,
    output logic              in_space,
    output logic              at_end
);
    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;
    logic              half;

    // Load a fresh byte or step through the mark and space halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            half  <= 1'b0;
        end else if (load) begin
            shreg <= byte_in;
            idx   <= '0;
            half  <= 1'b0;
        end else if (adv) begin
            half <= ~half;
            if (half) begin
                shreg <= shreg >> 1;
                idx   <= idx + IDX_W'(1);
            end
        end
    end

    assign bit_now  = shreg[0];
    assign in_space = half;
    assign at_end   = half && (idx == IDX_W'(BYTE_W - 1));

    // R3: a new byte and a half step never coincide
    a_r3_load_adv_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && adv));
endmodule

// File: rtl/esc_lane_tx.sv
// Escape-mode line transmitter for one lane.
// Drives entry pattern, spaced-one-hot command, optional payload bytes or
// ultra-low-power hold, then the exit pattern back to Stop.
// Assumes: period, wake_len are stable during a sequence; the line output
// decodes registered state only, so it changes only at clock edges.
module esc_lane_tx
    import esc_tx_pkg::*;
#(
    parameter int         PER_W    = 8,
    parameter int         WAKE_W   = 16,
    parameter logic [7:0] LPDT_CMD = 8'h87,
    parameter logic [7:0] ULPS_CMD = 8'h78
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [WAKE_W-1:0] wake_len,
    input  logic              esc_req,
    input  logic [7:0]        esc_cmd,
    input  logic              wake_req,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              data_last,
    output logic              data_ready,
    output logic              busy,
    output logic              lp_p,
    output logic              lp_n
);
    localparam int TMR_W = (WAKE_W > PER_W) ? WAKE_W : PER_W;

    esc_state_t     st, st_nx;
    logic [7:0]     cmd_q;
    logic           last_q;
    logic           tmr_load, tmr_done;
    logic [TMR_W-1:0] tmr_len;
    logic           ser_load, ser_adv, ser_bit, ser_space, ser_end;
    logic [7:0]     ser_byte;
    logic [1:0]     line;

    esc_phase_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .done(tmr_done)
    );

    esc_bit_serializer #(.BYTE_W(8)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .byte_in(ser_byte),
        .adv(ser_adv), .bit_now(ser_bit), .in_space(ser_space), .at_end(ser_end)
    );

    // Next phase, timer reload and serializer control.
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(period);
        ser_load = 1'b0;
        ser_byte = esc_cmd;
        ser_adv  = 1'b0;
        unique case (st)
            S_IDLE: if (esc_req) begin
                st_nx = S_ENT_10; tmr_load = 1'b1; ser_load = 1'b1;
            end
            S_ENT_10:  if (tmr_done) begin st_nx = S_ENT_00A; tmr_load = 1'b1; end
            S_ENT_00A: if (tmr_done) begin st_nx = S_ENT_01;  tmr_load = 1'b1; end
            S_ENT_01:  if (tmr_done) begin st_nx = S_ENT_00B; tmr_load = 1'b1; end
            S_ENT_00B: if (tmr_done) begin st_nx = S_CMD;     tmr_load = 1'b1; end
            S_CMD, S_DATA: if (tmr_done) begin
                tmr_load = 1'b1;
                if (!ser_end)
                    ser_adv = 1'b1;
                else if (st == S_DATA)
                    st_nx = last_q ? S_EXIT_10 : S_DWAIT;
                else if (cmd_q == LPDT_CMD)
                    st_nx = S_DWAIT;
                else if (cmd_q == ULPS_CMD)
                    st_nx = S_ULPS;
                else
                    st_nx = S_EXIT_10;
            end
            S_DWAIT: if (data_valid) begin
                st_nx = S_DATA; tmr_load = 1'b1; ser_load = 1'b1; ser_byte = data_byte;
            end
            S_ULPS: if (wake_req) begin
                st_nx = S_WAKE; tmr_load = 1'b1; tmr_len = TMR_W'(wake_len);
            end
            S_WAKE:    if (tmr_done) begin st_nx = S_EXIT_11; tmr_load = 1'b1; end
            S_EXIT_10: if (tmr_done) begin st_nx = S_EXIT_11; tmr_load = 1'b1; end
            S_EXIT_11: if (tmr_done) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // Phase register plus the command and last-byte flags it decides on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cmd_q  <= '0;
            last_q <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == S_IDLE && esc_req)
                cmd_q <= esc_cmd;
            if (st == S_DWAIT && data_valid)
                last_q <= data_last;
        end
    end

    // Line pair decoded from the current phase and serializer half.
    always_comb begin
        unique case (st)
            S_ENT_10, S_WAKE, S_EXIT_10:        line = LINE_MARK1;
            S_ENT_01:                            line = LINE_MARK0;
            S_ENT_00A, S_ENT_00B, S_DWAIT, S_ULPS: line = LINE_SPACE;
            S_CMD, S_DATA:
                line = ser_space ? LINE_SPACE : (ser_bit ? LINE_MARK1 : LINE_MARK0);
            default:                             line = LINE_STOP;
        endcase
    end

    assign lp_p       = line[1];
    assign lp_n       = line[0];
    assign data_ready = (st == S_DWAIT);
    assign busy       = (st != S_IDLE);

    // R11: a Mark-0 never turns straight into a Mark-1
    a_r11_mark0_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ({lp_p, lp_n} == 2'b01) |=> ({lp_p, lp_n} != 2'b10));
    // R11: a Mark-1 never turns straight into a Mark-0
    a_r11_mark1_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ({lp_p, lp_n} == 2'b10) |=> ({lp_p, lp_n} != 2'b01));
    // R11: Stop is left only towards LP-10
    a_r11_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ({lp_p, lp_n} == 2'b11) |=> ({lp_p, lp_n} == 2'b11 || {lp_p, lp_n} == 2'b10));
    // R5: byte wait is offered only on a space
    a_r5_ready_on_space: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> ({lp_p, lp_n} == 2'b00));
    // R5: a taken byte closes the ready window for the next cycle
    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && data_valid) |=> !data_ready);
    // R1: idle means Stop on the lines
    a_r1_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({lp_p, lp_n} == 2'b11 && !data_ready));
endmodule

// File: tb/esc_lane_tx_tb.sv
module esc_lane_tx_tb;
    localparam int PER_W  = 8;
    localparam int WAKE_W = 16;
    localparam logic [7:0] LPDT = 8'h87;
    localparam logic [7:0] ULPS = 8'h78;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PER_W-1:0]  period = 8'd2;
    logic [WAKE_W-1:0] wake_len = 16'd5;
    logic esc_req = 1'b0, wake_req = 1'b0;
    logic [7:0] esc_cmd = '0, data_byte = '0;
    logic data_valid = 1'b0, data_last = 1'b0;
    logic data_ready, busy, lp_p, lp_n;

    always #2 clk = ~clk;

    esc_lane_tx #(.PER_W(PER_W), .WAKE_W(WAKE_W), .LPDT_CMD(LPDT), .ULPS_CMD(ULPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .period(period), .wake_len(wake_len),
        .esc_req(esc_req), .esc_cmd(esc_cmd), .wake_req(wake_req),
        .data_valid(data_valid), .data_byte(data_byte), .data_last(data_last),
        .data_ready(data_ready), .busy(busy), .lp_p(lp_p), .lp_n(lp_n)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] hold_v = 2'b11;
    bit lpdt_wait = 0, ulps_wait = 0;
    bit m_idle = 0, m_rdy = 0, m_ulps = 0;
    logic [1:0] prev_line = 2'b11;

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic push_n(input logic [1:0] v, input int n, input string t);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(v);
            tag_q.push_back(t);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input int p, input string t);
        for (int i = 0; i < 8; i++) begin
            push_n(b[i] ? 2'b10 : 2'b01, p, t);
            push_n(2'b00, p, t);
        end
    endtask

    // Events seen at the edge extend the expected line waveform.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete(); tag_q.delete();
            hold_v = 2'b11; lpdt_wait = 0; ulps_wait = 0;
            m_idle = 0; m_rdy = 0; m_ulps = 0;
        end else begin
            int p;
            p = eff(int'(period));
            if (m_idle && esc_req) begin
                push_n(2'b10, p, "R2"); push_n(2'b00, p, "R2");
                push_n(2'b01, p, "R2"); push_n(2'b00, p, "R2");
                push_byte(esc_cmd, p, "R3");
                if (esc_cmd == LPDT) begin
                    hold_v = 2'b00; lpdt_wait = 1;
                end else if (esc_cmd == ULPS) begin
                    hold_v = 2'b00; ulps_wait = 1;
                end else begin
                    push_n(2'b10, p, "R9"); push_n(2'b11, p, "R9");
                    hold_v = 2'b11;
                end
            end
            if (m_rdy && data_valid) begin
                push_byte(data_byte, p, "R5");
                if (data_last) begin
                    push_n(2'b10, p, "R7"); push_n(2'b11, p, "R7");
                    hold_v = 2'b11; lpdt_wait = 0;
                end
            end
            if (m_ulps && wake_req) begin
                push_n(2'b10, eff(int'(wake_len)), "R8");
                push_n(2'b11, p, "R8");
                hold_v = 2'b11; ulps_wait = 0;
            end
        end
    end

    // Every cycle: compare the ports with the model, then advance it.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] e, a;
            string t;
            bit empty;
            empty = (exp_q.size() == 0);
            e = empty ? hold_v : exp_q[0];
            t = empty ? (hold_v == 2'b11 ? "R1" : (lpdt_wait ? "R6" : "R8")) : tag_q[0];
            a = {lp_p, lp_n};
            chk(a == e, t, int'(a), int'(e));
            chk(data_ready == (empty && lpdt_wait), "R5 ready", int'(data_ready),
                int'(empty && lpdt_wait));
            chk(busy == !(empty && hold_v == 2'b11), "R1 busy", int'(busy),
                int'(!(empty && hold_v == 2'b11)));
            chk(!((prev_line == 2'b01 && a == 2'b10) || (prev_line == 2'b10 && a == 2'b01) ||
                  (prev_line == 2'b11 && a != 2'b11 && a != 2'b10)),
                "R11 step", int'(a), int'(prev_line));
            prev_line = a;
            m_idle = empty && hold_v == 2'b11;
            m_rdy  = empty && lpdt_wait;
            m_ulps = empty && ulps_wait;
            if (!empty) begin
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end else begin
            prev_line = 2'b11;
        end
    end

    // ---------------- stimulus ----------------
    task automatic start_seq(input logic [7:0] c);
        @(negedge clk);
        while (busy) @(negedge clk);
        esc_req = 1'b1; esc_cmd = c;
        @(negedge clk);
        esc_req = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last, input int gap);
        repeat (gap) @(negedge clk);
        data_valid = 1'b1; data_byte = b; data_last = last;
        while (!data_ready) @(negedge clk);
        @(negedge clk);
        data_valid = 1'b0; data_last = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk({lp_p, lp_n} == 2'b11, "R1 reset line", int'({lp_p, lp_n}), 3);
        chk(!busy && !data_ready, "R1 reset flags", int'({busy, data_ready}), 0);

        // R5/R7: three bytes back to back, period 2, with a stray request (R10)
        period = 8'd2;
        start_seq(LPDT);
        repeat (10) @(negedge clk);
        esc_req = 1'b1; esc_cmd = ULPS;   // R10: must be ignored
        @(negedge clk);
        esc_req = 1'b0;
        send_byte(8'hA5, 0, 0);
        send_byte(8'h3C, 0, 0);
        send_byte(8'hFF, 1, 0);
        wait_idle();

        // R6: stalled stream, period 3
        period = 8'd3;
        start_seq(LPDT);
        send_byte(8'h00, 0, 0);
        send_byte(8'h81, 1, 40);
        wait_idle();

        // R8: ultra-low-power hold, period 1, wake after a long wait
        period = 8'd1; wake_len = 16'd6;
        start_seq(ULPS);
        repeat (45) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_idle();

        // R9/R4: other command with period 0, stray wake pulse ignored
        period = 8'd0;
        start_seq(8'h5D);
        repeat (5) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_idle();

        // R4/R8: zero wake length, period 2
        period = 8'd2; wake_len = 16'd0;
        start_seq(ULPS);
        repeat (50) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_idle();

        // R3: one-byte payload of alternating bits, period 1
        period = 8'd1;
        start_seq(LPDT);
        send_byte(8'h55, 1, 3);
        wait_idle();

        // R1: back at Stop at the end
        chk({lp_p, lp_n} == 2'b11, "R1 end line", int'({lp_p, lp_n}), 3);
        chk(!busy, "R1 end busy", int'(busy), 0);
        chk(exp_q.size() == 0, "R7 model drained", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule